// File: doc/BRIEF.md
# Time Base and Decrementer Timer

This block keeps two timing counters for a processor core. A 64-bit time base counts up by one on each qualified tick, and a 32-bit decrementer counts down by one on the same tick. Both stop while a freeze input is high and pick up from where they stopped when it falls. Software loads the time base through two 32-bit half writes and loads the decrementer with a full 32-bit write, all through one write port with a two-bit target selector.

The decrementer raises an interrupt request when its count passes from zero to all-ones, the point where its most significant bit turns on. A static configuration input picks between two request styles. In edge style the request is sticky until the core acknowledges it. In level style the request follows the sign of written values and ignores acknowledges. A second static input makes the decrementer stop at zero instead of wrapping. In that case the request fires when the count arrives at zero. Writes can raise or drop the request in the same cycle that they load the count.

Top module: `tbd_core`

## Requirements
- R1: A write with selector 0 (time base low half) puts `wr_data` into time base bits 31:0 on the next clock and leaves bits 63:32 unchanged.
- R2: A write with selector 1 (time base high half) puts `wr_data` into time base bits 63:32 on the next clock and leaves bits 31:0 unchanged.
- R3: On a clock where `tick_en` is high, `freeze` is low and no time base write occurs, the time base grows by exactly one, with carry across the halves. A time base write in the same cycle takes the place of the increment.
- R4: Without saturation, each qualified tick lowers the decrementer by one. A tick at zero gives 0xFFFFFFFF and sets `dec_irq` on the same clock edge.
- R5: While `freeze` is high, ticks change neither counter. After `freeze` falls, counting resumes from the held values.
- R6: Synchronous reset gives a time base of 0, a decrementer of 0xFFFFFFFF and `dec_irq` low.
- R7: In edge style (`cfg_level_mode` = 0), a decrementer write sets `dec_irq` when the new value has bit 31 set and the old count had bit 31 clear. A write with bit 31 set over a count that already has bit 31 set does not raise the request.
- R8: In level style (`cfg_level_mode` = 1), a decrementer write with bit 31 set raises `dec_irq`. A decrementer write with bit 31 clear and a value above 1 lowers it.
- R9: A decrementer write of 0 or 1 raises `dec_irq` in either style.
- R10: In edge style `irq_ack` clears `dec_irq` on the next clock unless a new event occurs in the same cycle. In level style `irq_ack` has no effect.
- R11: With `cfg_saturate` = 1 the decrementer holds at zero under further ticks, and the tick that takes it from 1 to 0 raises `dec_irq`.
- R12: A decrementer write with selector 2 takes priority over a tick in the same cycle. Selector 3 writes nothing, and a tick in that cycle still counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-advance strobe for both counters |
| freeze | input | 1 | Holds both counters while high |
| cfg_level_mode | input | 1 | Static: 1 selects level-style request, 0 edge style |
| cfg_saturate | input | 1 | Static: 1 makes the decrementer stop at zero |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 time base low, 1 time base high, 2 decrementer, 3 none |
| wr_data | input | 32 | Write data |
| irq_ack | input | 1 | Core acknowledges delivery of the request |
| tb_value | output | 64 | Registered time base |
| dec_value | output | 32 | Registered decrementer |
| dec_irq | output | 1 | Registered decrementer interrupt request |

## Verification
A wrong counter state shows on `tb_value` or `dec_value` on the very next clock, because both outputs are the counters themselves. The bench therefore checks after each single cycle instead of after long runs. A wrong request state is harder to see. It only shows on `dec_irq` at the zero crossing, at a write, or at an acknowledge. For that reason, the bench drives the count through zero in both the wrapping and the saturating form, writes values on both sides of bit 31 over old counts of either sign, and acknowledges under both request styles, checking `dec_irq` one clock after each event.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

  // Write target selector; values are part of the port contract.
  typedef enum logic [1:0] {
    SEL_TB_LO = 2'd0,
    SEL_TB_HI = 2'd1,
    SEL_DEC   = 2'd2,
    SEL_NONE  = 2'd3
  } wr_sel_e;

endpackage

// File: rtl/tbd_timebase.sv
module tbd_timebase #(
  parameter int TB_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                advance,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [TB_W/2-1:0]   wr_data,
  output logic [TB_W-1:0]     tb_q
);
  localparam int HALF_W = TB_W / 2;

  logic [TB_W-1:0] tb_inc;
  logic [TB_W-1:0] tb_loaded;
  logic [1:0]      half_wr;

  assign tb_inc  = tb_q + TB_W'(1);
  assign half_wr = {wr_hi, wr_lo};

  // Each half either takes the write data or keeps its current value.
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign tb_loaded[h*HALF_W +: HALF_W] =
      half_wr[h] ? wr_data : tb_q[h*HALF_W +: HALF_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tb_q <= '0;
    end else if (wr_lo || wr_hi) begin
      tb_q <= tb_loaded;
    end else if (advance) begin
      tb_q <= tb_inc;
    end
  end

endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer #(
  parameter int DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             saturate,
  input  logic             wr_en,
  input  logic [DEC_W-1:0] wr_data,
  output logic [DEC_W-1:0] dec_q,
  output logic             tick_event,
  output logic             old_msb
);
  localparam logic [DEC_W-1:0] DEC_ONE  = DEC_W'(1);
  localparam logic [DEC_W-1:0] DEC_INIT = '1;

  logic at_zero;
  logic at_one;
  logic hold;

  assign at_zero = (dec_q == '0);
  assign at_one  = (dec_q == DEC_ONE);
  assign hold    = saturate && at_zero;
  assign old_msb = dec_q[DEC_W-1];

  // Event: wrap 0 -> all-ones, or arrival at zero when saturating.
  assign tick_event = advance && !wr_en && (saturate ? at_one : at_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q <= DEC_INIT;
    end else if (wr_en) begin
      dec_q <= wr_data;
    end else if (advance && !hold) begin
      dec_q <= dec_q - DEC_ONE;
    end
  end

endmodule

// File: rtl/tbd_irq_ctrl.sv
module tbd_irq_ctrl #(
  parameter int DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             level_mode,
  input  logic             tick_event,
  input  logic             wr_en,
  input  logic [DEC_W-1:0] wr_data,
  input  logic             old_msb,
  input  logic             ack,
  output logic             irq_q
);
  logic new_msb;
  logic small_val;
  logic wr_raise;
  logic set_req;
  logic clr_req;

  assign new_msb   = wr_data[DEC_W-1];
  assign small_val = (wr_data <= DEC_W'(1));

  always_comb begin
    if (level_mode) begin
      wr_raise = small_val || new_msb;
      clr_req  = wr_en && !new_msb && !small_val;
    end else begin
      wr_raise = small_val || (new_msb && !old_msb);
      clr_req  = ack;
    end
  end

  assign set_req = tick_event || (wr_en && wr_raise);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else if (set_req) begin
      irq_q <= 1'b1;
    end else if (clr_req) begin
      irq_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tbd_core.sv
module tbd_core #(
  parameter int TB_W  = 64,
  parameter int DEC_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               freeze,
  input  logic               cfg_level_mode,
  input  logic               cfg_saturate,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [TB_W/2-1:0]  wr_data,
  input  logic               irq_ack,
  output logic [TB_W-1:0]    tb_value,
  output logic [DEC_W-1:0]   dec_value,
  output logic               dec_irq
);
  import tbd_pkg::*;

  logic advance;
  logic wr_tb_lo;
  logic wr_tb_hi;
  logic wr_dec;
  logic dec_event;
  logic dec_old_msb;
  logic [DEC_W-1:0] dec_wdata;

  assign advance   = tick_en && !freeze;
  assign wr_tb_lo  = wr_en && (wr_sel == SEL_TB_LO);
  assign wr_tb_hi  = wr_en && (wr_sel == SEL_TB_HI);
  assign wr_dec    = wr_en && (wr_sel == SEL_DEC);
  assign dec_wdata = DEC_W'(wr_data);

  tbd_timebase #(.TB_W(TB_W)) tb_i (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .wr_lo   (wr_tb_lo),
    .wr_hi   (wr_tb_hi),
    .wr_data (wr_data),
    .tb_q    (tb_value)
  );

  tbd_decrementer #(.DEC_W(DEC_W)) dec_i (
    .clk        (clk),
    .rst        (rst),
    .advance    (advance),
    .saturate   (cfg_saturate),
    .wr_en      (wr_dec),
    .wr_data    (dec_wdata),
    .dec_q      (dec_value),
    .tick_event (dec_event),
    .old_msb    (dec_old_msb)
  );

  tbd_irq_ctrl #(.DEC_W(DEC_W)) irq_i (
    .clk        (clk),
    .rst        (rst),
    .level_mode (cfg_level_mode),
    .tick_event (dec_event),
    .wr_en      (wr_dec),
    .wr_data    (dec_wdata),
    .old_msb    (dec_old_msb),
    .ack        (irq_ack),
    .irq_q      (dec_irq)
  );

endmodule

// File: rtl/tbd_core_chk.sv
module tbd_core_chk #(
  parameter int TB_W  = 64,
  parameter int DEC_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               tick_en,
  input logic               freeze,
  input logic               cfg_level_mode,
  input logic               cfg_saturate,
  input logic               wr_en,
  input logic [1:0]         wr_sel,
  input logic [TB_W/2-1:0]  wr_data,
  input logic               irq_ack,
  input logic [TB_W-1:0]    tb_value,
  input logic [DEC_W-1:0]   dec_value,
  input logic               dec_irq
);
  localparam int HALF_W = TB_W / 2;

  logic adv;
  logic wr_tb;
  logic wr_dc;
  assign adv   = tick_en && !freeze;
  assign wr_tb = wr_en && (wr_sel == 2'd0 || wr_sel == 2'd1);
  assign wr_dc = wr_en && (wr_sel == 2'd2);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (tb_value == '0 && dec_value == '1 && !dec_irq)); // R6

  AST_TB_LO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0) |=>
      (tb_value[HALF_W-1:0] == $past(wr_data) &&
       tb_value[TB_W-1:HALF_W] == $past(tb_value[TB_W-1:HALF_W]))); // R1

  AST_TB_HI_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd1) |=>
      (tb_value[TB_W-1:HALF_W] == $past(wr_data) &&
       tb_value[HALF_W-1:0] == $past(tb_value[HALF_W-1:0]))); // R2

  AST_TB_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_tb) |=> tb_value == $past(tb_value) + TB_W'(1)); // R3

  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_dc && !cfg_saturate && dec_value == '0) |=>
      (dec_value == '1 && dec_irq)); // R4

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (freeze && !wr_en) |=> ($stable(tb_value) && $stable(dec_value))); // R5

  AST_SMALL_WRITE_RAISES: assert property (@(posedge clk) disable iff (rst)
    (wr_dc && wr_data <= HALF_W'(1)) |=> dec_irq); // R9

  AST_LEVEL_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_level_mode && dec_irq && irq_ack && !wr_dc) |=> dec_irq); // R10

  AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!cfg_level_mode && irq_ack && !wr_en && !adv) |=> !dec_irq); // R10

  AST_SAT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (cfg_saturate && dec_value == '0 && !wr_dc) |=> dec_value == '0); // R11

  AST_DEC_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_dc |=> dec_value == DEC_W'($past(wr_data))); // R12

endmodule

bind tbd_core tbd_core_chk #(.TB_W(TB_W), .DEC_W(DEC_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .tick_en        (tick_en),
  .freeze         (freeze),
  .cfg_level_mode (cfg_level_mode),
  .cfg_saturate   (cfg_saturate),
  .wr_en          (wr_en),
  .wr_sel         (wr_sel),
  .wr_data        (wr_data),
  .irq_ack        (irq_ack),
  .tb_value       (tb_value),
  .dec_value      (dec_value),
  .dec_irq        (dec_irq)
);

// File: tb/tbd_core_tb.sv
`timescale 1ns/1ps
module tbd_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        freeze = 1'b0;
  logic        cfg_level_mode = 1'b0;
  logic        cfg_saturate = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        irq_ack = 1'b0;
  logic [63:0] tb_value;
  logic [31:0] dec_value;
  logic        dec_irq;

  int checks = 0;
  int failures = 0;
  int cyc_cnt = 0;

  always #5 clk = ~clk;

  tbd_core dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .freeze(freeze),
    .cfg_level_mode(cfg_level_mode), .cfg_saturate(cfg_saturate),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack),
    .tb_value(tb_value), .dec_value(dec_value), .dec_irq(dec_irq)
  );

  // Vector: wr(1) sel(2) data(32) tick(1) ack(1) exp_dec(32) exp_irq(1)
  localparam int NV = 14;
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 2'd2, 32'd3,          1'b0, 1'b0, 32'd3,          1'b0}, // R7 no raise
    {1'b0, 2'd0, 32'd0,          1'b1, 1'b0, 32'd2,          1'b0}, // R4
    {1'b0, 2'd0, 32'd0,          1'b1, 1'b0, 32'd1,          1'b0}, // R4
    {1'b0, 2'd0, 32'd0,          1'b1, 1'b0, 32'd0,          1'b0}, // R4
    {1'b0, 2'd0, 32'd0,          1'b1, 1'b0, 32'hFFFF_FFFF,  1'b1}, // R4 wrap
    {1'b0, 2'd0, 32'd0,          1'b0, 1'b1, 32'hFFFF_FFFF,  1'b0}, // R10
    {1'b1, 2'd2, 32'h8000_0000,  1'b0, 1'b0, 32'h8000_0000,  1'b0}, // R7 old msb set
    {1'b1, 2'd2, 32'd10,         1'b0, 1'b0, 32'd10,         1'b0}, // R7
    {1'b1, 2'd2, 32'h8000_0005,  1'b0, 1'b0, 32'h8000_0005,  1'b1}, // R7 raise
    {1'b0, 2'd0, 32'd0,          1'b1, 1'b1, 32'h8000_0004,  1'b0}, // R10
    {1'b1, 2'd2, 32'd1,          1'b0, 1'b0, 32'd1,          1'b1}, // R9
    {1'b0, 2'd0, 32'd0,          1'b0, 1'b1, 32'd1,          1'b0}, // R10
    {1'b1, 2'd2, 32'd7,          1'b1, 1'b0, 32'd7,          1'b0}, // R12
    {1'b1, 2'd3, 32'd0,          1'b1, 1'b0, 32'd6,          1'b0}  // R12 sel 3
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // One clock: drive at falling edge, sample 1 ns after rising edge.
  task automatic cyc(input logic w, input logic [1:0] s, input logic [31:0] d,
                     input logic t, input logic a);
    @(negedge clk);
    wr_en = w; wr_sel = s; wr_data = d; tick_en = t; irq_ack = a;
    @(posedge clk);
    #1;
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; tick_en = 1'b0; irq_ack = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 50000) begin
      failures++;
      $display("FAIL watchdog all-reqs actual=%0d expected<=%0d", cyc_cnt, 50000);
      finish_run();
    end
  end

  initial begin
    logic [63:0] tb_hold;
    logic [31:0] dec_hold;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    chk("R6 tb reset",  tb_value, 64'd0);
    chk("R6 dec reset", {32'd0, dec_value}, 64'h0000_0000_FFFF_FFFF);
    chk("R6 irq reset", {63'd0, dec_irq}, 64'd0);

    // Edge-style decrementer table
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][69], VEC[i][68:67], VEC[i][66:35], VEC[i][34], VEC[i][33]);
      chk($sformatf("R4/R7/R9/R10/R12 vec%0d dec", i), {32'd0, dec_value}, {32'd0, VEC[i][32:1]});
      chk($sformatf("R4/R7/R9/R10/R12 vec%0d irq", i), {63'd0, dec_irq}, {63'd0, VEC[i][0]});
    end

    // Time base halves and carry
    cyc(1'b1, 2'd0, 32'hFFFF_FFFE, 1'b0, 1'b0);
    cyc(1'b1, 2'd1, 32'h0000_0001, 1'b0, 1'b0);
    chk("R1 R2 tb halves", tb_value, 64'h0000_0001_FFFF_FFFE);
    cyc(1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
    cyc(1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
    chk("R3 tb carry", tb_value, 64'h0000_0002_0000_0000);
    cyc(1'b1, 2'd0, 32'h1234_5678, 1'b1, 1'b0);
    chk("R1 low write over tick", tb_value, 64'h0000_0002_1234_5678);
    cyc(1'b1, 2'd1, 32'hAABB_CCDD, 1'b0, 1'b0);
    chk("R2 high write keeps low", tb_value, 64'hAABB_CCDD_1234_5678);

    // Freeze
    tb_hold = tb_value; dec_hold = dec_value;
    @(negedge clk) freeze = 1'b1;
    for (int k = 0; k < 5; k++) cyc(1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
    chk("R5 tb frozen",  tb_value, tb_hold);
    chk("R5 dec frozen", {32'd0, dec_value}, {32'd0, dec_hold});
    @(negedge clk) freeze = 1'b0;
    cyc(1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
    chk("R5 tb resumes",  tb_value, tb_hold + 64'd1);
    chk("R5 dec resumes", {32'd0, dec_value}, {32'd0, dec_hold - 32'd1});

    // Level style
    @(negedge clk) cfg_level_mode = 1'b1;
    cyc(1'b1, 2'd2, 32'h8000_0000, 1'b0, 1'b0);
    chk("R8 level msb write raises", {63'd0, dec_irq}, 64'd1);
    cyc(1'b0, 2'd0, 32'd0, 1'b0, 1'b1);
    chk("R10 level ack ignored", {63'd0, dec_irq}, 64'd1);
    cyc(1'b1, 2'd2, 32'd100, 1'b0, 1'b0);
    chk("R8 level clear write lowers", {63'd0, dec_irq}, 64'd0);
    cyc(1'b1, 2'd2, 32'd0, 1'b0, 1'b0);
    chk("R9 level zero write raises", {63'd0, dec_irq}, 64'd1);
    cyc(1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
    chk("R4 level wrap dec", {32'd0, dec_value}, 64'h0000_0000_FFFF_FFFF);
    chk("R4 level wrap irq", {63'd0, dec_irq}, 64'd1);
    cyc(1'b1, 2'd2, 32'd50, 1'b0, 1'b0);
    chk("R8 level lower again", {63'd0, dec_irq}, 64'd0);

    // Saturating, edge style
    @(negedge clk) begin cfg_level_mode = 1'b0; cfg_saturate = 1'b1; end
    cyc(1'b1, 2'd2, 32'd2, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
    chk("R11 sat at one irq", {63'd0, dec_irq}, 64'd0);
    cyc(1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
    chk("R11 sat reach zero dec", {32'd0, dec_value}, 64'd0);
    chk("R11 sat reach zero irq", {63'd0, dec_irq}, 64'd1);
    cyc(1'b0, 2'd0, 32'd0, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) cyc(1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
    chk("R11 sat holds zero", {32'd0, dec_value}, 64'd0);
    chk("R11 sat no repeat irq", {63'd0, dec_irq}, 64'd0);

    finish_run();
  end

endmodule